// File: doc/BRIEF.md
# Multi-Line Transmit DMA Scheduler

This block keeps the transmit state of sixteen serial lines and fetches their output bytes from memory. Each line owns an 18-bit current address and a 16-bit byte counter. Software reaches them through one shared register window. A line-select field in the control register decides which line that window shows. Software loads the address and the negated byte count of a line, then sets the line's bit in the active register. From then on the hardware moves that line's bytes from memory into a one-byte holding stage. Each line presents its holding stage on its own ready/valid output, which feeds a serialiser outside this block.

Memory is reached over a simple read port with one request in flight at a time. A round-robin arbiter picks the next line to serve from the active lines whose holding stage is empty. Each grant fetches one byte. When a line's counter reaches zero, the hardware clears the line's active bit and raises a transmit-done flag, which can drive an interrupt.

Software can stop a busy line early by writing a count of minus one. A fetch that returns an error sets a memory-error flag and stops the faulting line. A break register holds one bit per line and drives a per-line break request to the serialisers.

Top module: `txdma_sched`

## Requirements
- R1: After reset, every register reads zero, no memory request is raised, no line presents a byte, `irq_o` is low and `brk_o` is zero.
- R2: The register addresses are: control 0, current address 1, count 2, active 3, break 4. Control bits 3:0 select the line whose current-address and count registers are read and written at addresses 1 and 2. Every line keeps its own pair of values.
- R3: A control write stores bits 5:4 as address bits 17:16 of the newly selected line. Control bits 5:4 read back those bits for the selected line. A fetch uses `mem_addr_o = {bits 17:16, current address}`, and the 18-bit address increments with a carry from bit 15 into bit 16.
- R4: A count written as the two's-complement negative of N makes the line deliver exactly N bytes from consecutive addresses. Afterwards the count reads 0 and the current address reads start+N.
- R5: On the last byte, the line's active bit clears and control bit 15 (done) is set. `irq_o` equals done AND control bit 13 (enable). A control write with bit 15 at 0 clears done. Writing bit 15 as 1 never sets it.
- R6: Writing a count of 0xFFFF to a line that is still active lets the line deliver exactly one more byte before it stops.
- R7: A fetch answered with `mem_err_i` sets control bit 10 and clears the line's active bit. It delivers no byte, leaves the line's address and count unchanged, and does not set done. A control write with bit 8 at 1 clears bit 10.
- R8: The break register holds one bit per line. It reads back what was written and drives `brk_o`.
- R9: The memory port has at most one read in flight. `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`.
- R10: A line is eligible when it is active and its holding stage is empty. Eligible lines are granted one byte at a time in rising circular order, starting after the last granted line. After reset, line 0 comes first.
- R11: A byte on `tx_valid_o`/`tx_data_o` stays valid and unchanged until `tx_ready_i`. A line whose holding stage is full is not fetched for.
- R12: A write to the active register starts every line whose bit is 1. Bits written as 0 have no effect on lines already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Transmit-done interrupt |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 18 | Memory byte address |
| mem_ack_i | input | 1 | Memory response |
| mem_err_i | input | 1 | Response is an error (valid with ack) |
| mem_rdata_i | input | 8 | Read byte (valid with ack) |
| tx_valid_o | output | 16 | Per-line byte valid |
| tx_data_o | output | 128 | Per-line byte, line i at bits 8i+7:8i |
| tx_ready_i | input | 16 | Per-line byte accepted |
| brk_o | output | 16 | Per-line break request |

## Verification
Register writes take effect at the edge that samples the strobe, and reads are combinational, so the bench samples read data one time step after it sets the address. A grant raises `mem_req_o` at the next edge. The bench's memory answers on the second cycle of the request. The fetched byte, the counter and address increment and any completion all land at the acknowledging edge, so one byte takes three cycles. Completion times depend on arbitration, so the checks do not count fixed delays: they poll the active register until the line's bit clears and then compare the final register values. A scoreboard pops the expected bytes per line at every negative edge where valid and ready are both high, and the order of grants is checked from the memory model's address log.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_CADDR = 3'd1,
    REG_CNT   = 3'd2,
    REG_ACT   = 3'd3,
    REG_BRK   = 3'd4
  } reg_sel_e;

  localparam int CTRL_DONE    = 15;
  localparam int CTRL_IEN     = 13;
  localparam int CTRL_MERR    = 10;
  localparam int CTRL_MERR_CL = 8;
  localparam int CTRL_EXT_LO  = 4;
endpackage

// File: rtl/tdma_rr_arb.sv
module tdma_rr_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o,
  output logic          any_o
);
  logic [IW-1:0] last_q;

  assign any_o = |req_i;

  always_comb begin
    logic found;
    found     = 1'b0;
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req_i[c]) begin
        found     = 1'b1;
        gnt_o[c]  = 1'b1;
        gnt_idx_o = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               last_q <= IW'(N - 1);
    else if (adv_i && any_o)   last_q <= gnt_idx_o;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R10
  AST_GNT_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R10
endmodule

// File: rtl/tdma_hold_buf.sv
module tdma_hold_buf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  input  logic          ready_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R11
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R11
endmodule

// File: rtl/txdma_sched.sv
module txdma_sched
  import tdma_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DW     = 8,
  parameter int ALO    = 16,
  parameter int AHI    = 2,
  parameter int CW     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [15:0]          reg_wdata_i,
  output logic [15:0]          reg_rdata_o,
  output logic                 irq_o,
  output logic                 mem_req_o,
  output logic [ALO+AHI-1:0]   mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic                 mem_err_i,
  input  logic [DW-1:0]        mem_rdata_i,
  output logic [NLINES-1:0]    tx_valid_o,
  output logic [NLINES*DW-1:0] tx_data_o,
  input  logic [NLINES-1:0]    tx_ready_i,
  output logic [NLINES-1:0]    brk_o
);
  localparam int SEL_W = $clog2(NLINES);
  localparam int AW    = ALO + AHI;

  logic [SEL_W-1:0]  sel_q;
  logic              ien_q, done_q, merr_q;
  logic [ALO-1:0]    alo_q [NLINES];
  logic [AHI-1:0]    ahi_q [NLINES];
  logic [CW-1:0]     cnt_q [NLINES];
  logic [NLINES-1:0] act_q, brk_q;
  logic              busy_q;
  logic [SEL_W-1:0]  cur_q;
  logic [AW-1:0]     maddr_q;

  logic wr_ctrl, wr_caddr, wr_cnt, wr_act, wr_brk;
  assign wr_ctrl  = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_caddr = reg_we_i && (reg_addr_i == REG_CADDR);
  assign wr_cnt   = reg_we_i && (reg_addr_i == REG_CNT);
  assign wr_act   = reg_we_i && (reg_addr_i == REG_ACT);
  assign wr_brk   = reg_we_i && (reg_addr_i == REG_BRK);

  logic [SEL_W-1:0] new_sel;
  assign new_sel = reg_wdata_i[SEL_W-1:0];

  // fetch completion
  logic          ack_ok, ack_bad, last_byte;
  logic [AW-1:0] cur_addr_nxt;
  logic [CW-1:0] cur_cnt_nxt;
  assign ack_ok       = busy_q && mem_ack_i && !mem_err_i;
  assign ack_bad      = busy_q && mem_ack_i && mem_err_i;
  assign cur_addr_nxt = {ahi_q[cur_q], alo_q[cur_q]} + AW'(1);
  assign cur_cnt_nxt  = cnt_q[cur_q] + CW'(1);
  assign last_byte    = ack_ok && (cur_cnt_nxt == '0);

  // arbitration
  logic [NLINES-1:0] buf_valid, elig, gnt;
  logic [SEL_W-1:0]  gnt_idx;
  logic              gnt_any;
  assign elig = act_q & ~buf_valid;

  tdma_rr_arb #(.N(NLINES), .IW(SEL_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (elig),
    .adv_i     (!busy_q),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx),
    .any_o     (gnt_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      maddr_q <= '0;
    end else if (!busy_q && gnt_any) begin
      busy_q  <= 1'b1;
      cur_q   <= gnt_idx;
      maddr_q <= {ahi_q[gnt_idx], alo_q[gnt_idx]};
    end else if (busy_q && mem_ack_i) begin
      busy_q  <= 1'b0;
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = maddr_q;

  // per-line address and count; register writes win over the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NLINES; i++) begin
        alo_q[i] <= '0;
        ahi_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (ack_ok && cur_q == SEL_W'(i)) begin
          {ahi_q[i], alo_q[i]} <= cur_addr_nxt;
          cnt_q[i]             <= cur_cnt_nxt;
        end
        if (wr_caddr && sel_q == SEL_W'(i)) alo_q[i] <= reg_wdata_i[ALO-1:0];
        if (wr_ctrl && new_sel == SEL_W'(i))
          ahi_q[i] <= reg_wdata_i[CTRL_EXT_LO +: AHI];
        if (wr_cnt && sel_q == SEL_W'(i)) cnt_q[i] <= reg_wdata_i[CW-1:0];
      end
    end
  end

  // active mask, flags, control fields
  logic [NLINES-1:0] act_clr, act_set;
  assign act_clr = (last_byte || ack_bad) ? (NLINES'(1) << cur_q) : '0;
  assign act_set = wr_act ? reg_wdata_i[NLINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      brk_q  <= '0;
      sel_q  <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
      merr_q <= 1'b0;
    end else begin
      act_q <= (act_q & ~act_clr) | act_set;
      if (wr_brk) brk_q <= reg_wdata_i[NLINES-1:0];
      if (wr_ctrl) begin
        sel_q <= new_sel;
        ien_q <= reg_wdata_i[CTRL_IEN];
      end
      if (last_byte)                                done_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata_i[CTRL_DONE])  done_q <= 1'b0;
      if (ack_bad)                                  merr_q <= 1'b1;
      else if (wr_ctrl && reg_wdata_i[CTRL_MERR_CL]) merr_q <= 1'b0;
    end
  end

  assign irq_o = done_q && ien_q;
  assign brk_o = brk_q;

  // per-line holding stages
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    tdma_hold_buf #(.DW(DW)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ack_ok && cur_q == SEL_W'(g)),
      .data_i  (mem_rdata_i),
      .valid_o (buf_valid[g]),
      .data_o  (tx_data_o[g*DW +: DW]),
      .ready_i (tx_ready_i[g])
    );
  end
  assign tx_valid_o = buf_valid;

  // register read
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CTRL_DONE]              = done_q;
        reg_rdata_o[CTRL_IEN]               = ien_q;
        reg_rdata_o[CTRL_MERR]              = merr_q;
        reg_rdata_o[CTRL_EXT_LO +: AHI]     = ahi_q[sel_q];
        reg_rdata_o[SEL_W-1:0]              = sel_q;
      end
      REG_CADDR: reg_rdata_o = 16'(alo_q[sel_q]);
      REG_CNT:   reg_rdata_o = 16'(cnt_q[sel_q]);
      REG_ACT:   reg_rdata_o = 16'(act_q);
      REG_BRK:   reg_rdata_o = 16'(brk_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R9
  AST_MERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i && !wr_act
      |=> merr_q && !act_q[$past(cur_q)]); // R7
  AST_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_err_i && cnt_q[cur_q] == '1
      && !(wr_cnt && sel_q == cur_q) && !wr_act
      |=> done_q && !act_q[$past(cur_q)]); // R5
  AST_IDLE_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |=> $stable(cnt_q[$past(cur_q)]) || $past(wr_cnt)); // R4
endmodule

// File: tb/tb_txdma_sched.sv
`timescale 1ns/1ps
module tb_txdma_sched;
  localparam int NL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [NL-1:0]   tx_valid;
  logic [NL*8-1:0] tx_data;
  logic [NL-1:0]   tx_ready = '1;
  logic [NL-1:0]   brk;

  always #4 clk = ~clk;

  txdma_sched dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .brk_o(brk)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return a[7:0] ^ {a[17:16], a[13:8]} ^ 8'h3C;
  endfunction

  // memory model: answers on the second cycle of a request, errors above 0x2FFFF
  logic [17:0] addr_log[$];
  int          wait_cnt = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        if (wait_cnt == 1) begin
          mem_ack   = 1'b1;
          mem_err   = (mem_addr[17:16] == 2'b11);
          mem_rdata = mem_byte(mem_addr);
          addr_log.push_back(mem_addr);
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // scoreboard
  typedef struct packed { logic [3:0] line; logic [7:0] data; } exp_t;
  exp_t exp_q[$];

  function automatic int pending(input int line);
    int n = 0;
    foreach (exp_q[k]) if (int'(exp_q[k].line) == line) n++;
    return n;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < NL; i++) begin
        if (rst_n && tx_valid[i] && tx_ready[i]) begin
          int idx = -1;
          foreach (exp_q[k]) if (idx < 0 && int'(exp_q[k].line) == i) idx = k;
          if (idx < 0) begin
            check($sformatf("R4 unexpected byte line %0d", i), 32'(tx_data[i*8 +: 8]), 32'hFFFF);
          end else begin
            check($sformatf("R4 byte line %0d", i), 32'(tx_data[i*8 +: 8]), 32'(exp_q[idx].data));
            exp_q.delete(idx);
          end
        end
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] ctrl_w(input int line, input int ext, input bit ien, input bit mclr);
    return 16'(line) | (16'(ext) << 4) | (16'(ien) << 13) | (16'(mclr) << 8);
  endfunction

  task automatic setup_line(input int line, input int ext, input logic [15:0] a,
                            input int nbytes, input int npush);
    reg_wr(3'd0, ctrl_w(line, ext, 1'b1, 1'b0));
    reg_wr(3'd1, a);
    reg_wr(3'd2, 16'(-nbytes));
    for (int k = 0; k < npush; k++) begin
      exp_t e;
      e.line = 4'(line);
      e.data = mem_byte({2'(ext), a} + 18'(k));
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle(input int line, input string req);
    logic [15:0] d;
    int n = 0;
    do begin
      reg_rd(3'd3, d);
      n++;
    end while (d[line] && n < 2000);
    check({req, " line stops"}, 32'(d[line]), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] d;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd0, d); check("R1 ctrl", 32'(d), 0);
    reg_rd(3'd3, d); check("R1 active", 32'(d), 0);
    reg_rd(3'd2, d); check("R1 count", 32'(d), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 brk", 32'(brk), 0);

    // R2 line select keeps per-line registers apart
    reg_wr(3'd0, ctrl_w(3, 0, 0, 0)); reg_wr(3'd1, 16'h1234); reg_wr(3'd2, 16'hFFFB);
    reg_wr(3'd0, ctrl_w(5, 0, 0, 0)); reg_wr(3'd1, 16'hABCD); reg_wr(3'd2, 16'hFFF9);
    reg_rd(3'd1, d); check("R2 line5 addr", 32'(d), 32'hABCD);
    reg_wr(3'd0, ctrl_w(3, 0, 0, 0));
    reg_rd(3'd1, d); check("R2 line3 addr", 32'(d), 32'h1234);
    reg_rd(3'd2, d); check("R2 line3 count", 32'(d), 32'hFFFB);
    reg_rd(3'd0, d); check("R2 ctrl select", 32'(d[3:0]), 3);

    // R4/R5 single line transfer
    setup_line(3, 0, 16'h1234, 5, 5);
    reg_wr(3'd3, 16'h0008);
    wait_idle(3, "R5");
    repeat (3) @(posedge clk);
    check("R4 all bytes delivered", 32'(pending(3)), 0);
    reg_rd(3'd2, d); check("R4 count ends 0", 32'(d), 0);
    reg_rd(3'd1, d); check("R4 addr ends start+5", 32'(d), 32'h1239);
    reg_rd(3'd0, d); check("R5 done bit", 32'(d[15]), 1);
    check("R5 irq with enable", 32'(irq), 1);
    reg_wr(3'd0, ctrl_w(3, 0, 0, 0) | 16'h8000);
    reg_rd(3'd0, d); check("R5 writing 1 keeps done", 32'(d[15]), 1);
    check("R5 irq masked", 32'(irq), 0);
    reg_wr(3'd0, ctrl_w(3, 0, 1, 0));
    reg_rd(3'd0, d); check("R5 done cleared", 32'(d[15]), 0);
    check("R5 irq low", 32'(irq), 0);

    // R3 high address bits and carry
    addr_log.delete();
    setup_line(6, 1, 16'hFFFF, 2, 2);
    reg_wr(3'd3, 16'h0040);
    wait_idle(6, "R3");
    repeat (3) @(posedge clk);
    check("R3 byte count", 32'(pending(6)), 0);
    check("R9 one fetch per byte", 32'(addr_log.size()), 2);
    if (addr_log.size() == 2) begin
      check("R3 first address", 32'(addr_log[0]), 32'h1FFFF);
      check("R3 carry address", 32'(addr_log[1]), 32'h20000);
    end
    reg_rd(3'd0, d); check("R3 ext reads carry", 32'(d[5:4]), 2);
    reg_rd(3'd1, d); check("R3 low addr", 32'(d), 32'h0001);

    // R10 round robin across three lines
    setup_line(0, 0, 16'h0000, 3, 3);
    setup_line(1, 0, 16'h0100, 3, 3);
    setup_line(2, 0, 16'h0200, 3, 3);
    addr_log.delete();
    reg_wr(3'd3, 16'h0007);
    wait_idle(0, "R10"); wait_idle(1, "R10"); wait_idle(2, "R10");
    repeat (3) @(posedge clk);
    check("R10 fetch count", 32'(addr_log.size()), 9);
    if (addr_log.size() == 9)
      for (int k = 0; k < 9; k++)
        check($sformatf("R10 grant %0d", k), 32'(addr_log[k]),
              32'(((k % 3) << 8) | (k / 3)));
    check("R10 bytes delivered", 32'(exp_q.size()), 0);

    // R11 hold while not ready, R6 stop after one more byte
    tx_ready[4] = 1'b0;
    setup_line(4, 0, 16'h0400, 100, 2);
    addr_log.delete();
    reg_wr(3'd3, 16'h0010);
    begin
      int n = 0;
      while (!tx_valid[4] && n < 100) begin @(negedge clk); n++; end
    end
    @(negedge clk);
    d = 16'(tx_data[4*8 +: 8]);
    repeat (6) @(negedge clk);
    check("R11 valid held", 32'(tx_valid[4]), 1);
    check("R11 data stable", 32'(tx_data[4*8 +: 8]), 32'(d));
    check("R11 no fetch while full", 32'(addr_log.size()), 1);
    reg_wr(3'd0, ctrl_w(4, 0, 1, 0));
    reg_wr(3'd2, 16'hFFFF);
    @(posedge clk); #1 tx_ready[4] = 1'b1;
    wait_idle(4, "R6");
    repeat (4) @(posedge clk);
    check("R6 exactly one more byte", 32'(pending(4)), 0);
    check("R6 fetch total", 32'(addr_log.size()), 2);
    reg_rd(3'd1, d); check("R6 address shows progress", 32'(d), 32'h0402);
    check("R6 line quiet", 32'(tx_valid[4]), 0);

    // R7 memory error
    setup_line(7, 3, 16'h0010, 4, 0);
    reg_wr(3'd3, 16'h0080);
    wait_idle(7, "R7");
    repeat (3) @(posedge clk);
    reg_rd(3'd0, d);
    check("R7 error flag", 32'(d[10]), 1);
    check("R7 no done", 32'(d[15]), 0);
    reg_rd(3'd2, d); check("R7 count kept", 32'(d), 32'hFFFC);
    reg_rd(3'd1, d); check("R7 addr kept", 32'(d), 32'h0010);
    check("R7 no byte", 32'(tx_valid[7]), 0);
    reg_wr(3'd0, ctrl_w(7, 3, 1, 1));
    reg_rd(3'd0, d); check("R7 flag cleared", 32'(d[10]), 0);

    // R8 break register
    reg_wr(3'd4, 16'hA5A5);
    reg_rd(3'd4, d); check("R8 readback", 32'(d), 32'hA5A5);
    check("R8 brk_o", 32'(brk), 32'hA5A5);

    // R12 zero bits in active write do nothing
    setup_line(8, 0, 16'h0800, 6, 6);
    reg_wr(3'd3, 16'h0100);
    reg_wr(3'd3, 16'h0000);
    reg_rd(3'd3, d); check("R12 still active", 32'(d[8]), 1);
    wait_idle(8, "R12");
    repeat (3) @(posedge clk);
    check("R12 all bytes", 32'(pending(8)), 0);
    check("R4 scoreboard empty", 32'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule